// File: doc/BRIEF.md
# Host Register Bus Slave

This block is a clocked slave on a 16-bit microcontroller register bus. The host selects the block with a chip-select line, gives a read/write level and a 9-bit word address, and moves data on a shared 16-bit bidirectional bus. Each transfer ends with an acknowledge strobe from the block. The block holds a configuration word, an interrupt status/mask pair and a small bank of general word registers, and it signals pending interrupts to the host on an active-low interrupt line.

The active levels of chip select, the read/write line and the acknowledge output are set at run time by bits of the configuration word. The power-on defaults are chip select active low, read/write high meaning read, and acknowledge active low. Chip select and read/write pass through a two-flop synchroniser. The access controller has five states. `S_IDLE` waits for chip select. `S_ADDR` is the cycle after the address is captured. `S_EXEC` performs the write or captures read data. `S_ACK` holds acknowledge until chip select is released. `S_REARM` loads the new polarity settings and waits until chip select is inactive under them.

The transitions are as follows. `S_IDLE`→`S_ADDR` happens when synchronised chip select is active. `S_ADDR`→`S_EXEC` and `S_EXEC`→`S_ACK` are unconditional. `S_ACK`→`S_REARM` happens when synchronised chip select is inactive under the polarity in use for the access. `S_REARM`→`S_IDLE` happens when synchronised chip select is inactive under the newly loaded polarity.

Top module: `host_reg_slave`

## Requirements
- R1: After reset, acknowledge is high (inactive), the data bus is not driven, the interrupt output is high and the configuration word at address 0 reads 0.
- R2: Acknowledge asserts two clocks after the access starts. The access starts on the first clock where synchronised chip select is active. Counted from the clock on which the host changes chip select, acknowledge is seen after the fifth rising edge and not before.
- R3: Acknowledge stays asserted for as long as chip select is active, including the two synchroniser cycles after release. It deasserts on the third edge after release, and no new access starts until the controller has rearmed.
- R4: A write stores the bus word at the addressed general register (word addresses 3 to 10). A read of that address returns the stored word with bit 15 as MSB.
- R5: The block drives the data bus only while chip select is active, the access is a read and acknowledge is asserted. The bus is released as soon as the raw chip-select input goes inactive, and it is never driven during a write.
- R6: Configuration bit 0 set to 1 makes chip select active high; 0 makes it active low.
- R7: Configuration bit 1 set to 0 means read/write high is a read; set to 1, high is a write.
- R8: Configuration bit 2 set to 1 makes acknowledge active high. A polarity change takes effect from the next access: the acknowledge of the configuration write itself uses the old level.
- R9: After a chip-select polarity change, no access starts until chip select has been seen inactive under the new polarity.
- R10: Addresses above 10 read as 0, and writes to them change nothing.
- R11: A one-cycle pulse on event input bit i sets status bit i (word address 1). Writing 1 to a status bit clears it, and writing 0 leaves it unchanged.
- R12: The interrupt output goes low two clocks after an event on an unmasked bit (mask at word address 2, 1 = enabled). It stays high for masked bits and returns high once all enabled status bits are cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel_i | input | 1 | Chip select, programmable level |
| bus_rw_i | input | 1 | Read/write indicator, programmable sense |
| bus_addr_i | input | 9 | Word address |
| bus_data_io | inout | 16 | Bidirectional data bus |
| bus_ack_o | output | 1 | Access acknowledge, programmable level |
| host_irq_n_o | output | 1 | Interrupt to host, active low |
| evt_i | input | 8 | Interrupt event pulses, one per status bit |

## Verification
A chip-select change reaches the controller after two synchroniser edges. Acknowledge therefore appears after the fifth edge from the change and falls after the third edge from release. The interrupt output falls on the second edge after an event pulse. The bench drives inputs on falling edges and counts falling edges between a stimulus and each check, so every result is read at the exact cycle it is due. It also reads once in the cycle before, where the old value must still hold. Bus release is checked one time step after the chip-select change, through bench pull-ups that read all ones when nobody drives.

// File: rtl/hrs_pkg.sv
package hrs_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_ADDR,
        S_EXEC,
        S_ACK,
        S_REARM
    } acc_state_t;

    // bit 2: ack active high, bit 1: rw sense inverted, bit 0: select active high
    typedef struct packed {
        logic ack_hi;
        logic rw_inv;
        logic sel_hi;
    } pol_cfg_t;

    localparam int CFG_W     = 3;
    localparam int ADDR_CFG  = 0;
    localparam int ADDR_STAT = 1;
    localparam int ADDR_MASK = 2;
    localparam int ADDR_SCR0 = 3;

endpackage

// File: rtl/hrs_sync.sv
module hrs_sync #(
    parameter int         W       = 2,
    parameter logic [W-1:0] RST_VAL = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);

    logic [W-1:0] stage1_q;
    logic [W-1:0] stage2_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage1_q <= RST_VAL;
            stage2_q <= RST_VAL;
        end else begin
            stage1_q <= d_i;
            stage2_q <= stage1_q;
        end
    end

    assign q_o = stage2_q;

endmodule

// File: rtl/hrs_fsm.sv
module hrs_fsm
    import hrs_pkg::*;
#(
    parameter int AW = 9
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sel_s_i,
    input  logic          rw_s_i,
    input  logic          sel_raw_i,
    input  logic [AW-1:0] addr_i,
    input  pol_cfg_t      cfg_i,
    output logic          wr_en_o,
    output logic          rd_en_o,
    output logic [AW-1:0] addr_o,
    output logic          ack_o,
    output logic          drv_en_o
);

    acc_state_t    state_q;
    acc_state_t    state_d;
    pol_cfg_t      pol_q;
    logic          is_rd_q;
    logic [AW-1:0] addr_q;
    logic          sel_act;
    logic          sel_raw_act;
    logic          rw_is_rd;

    assign sel_act     = ~(sel_s_i ^ pol_q.sel_hi);
    assign sel_raw_act = ~(sel_raw_i ^ pol_q.sel_hi);
    assign rw_is_rd    = rw_s_i ^ pol_q.rw_inv;

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:  if (sel_act) state_d = S_ADDR;
            S_ADDR:  state_d = S_EXEC;
            S_EXEC:  state_d = S_ACK;
            S_ACK:   if (!sel_act) state_d = S_REARM;
            S_REARM: if (!sel_act) state_d = S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    // state register and per-access captures
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            pol_q   <= '0;
            is_rd_q <= 1'b0;
            addr_q  <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == S_IDLE && sel_act) begin
                is_rd_q <= rw_is_rd;
                addr_q  <= addr_i;
            end
            if (state_q == S_ACK && !sel_act) begin
                pol_q <= cfg_i;
            end
        end
    end

    // outputs
    always_comb begin
        wr_en_o  = (state_q == S_EXEC) && !is_rd_q;
        rd_en_o  = (state_q == S_EXEC) && is_rd_q;
        addr_o   = addr_q;
        ack_o    = ~((state_q == S_ACK) ^ pol_q.ack_hi);
        drv_en_o = (state_q == S_ACK) && is_rd_q && sel_raw_act;
    end

    AST_ADDR_TO_EXEC: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == S_ADDR |=> state_q == S_EXEC); // R2
    AST_EXEC_TO_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == S_EXEC |=> state_q == S_ACK); // R2
    AST_ACK_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_ACK && sel_act) |=> state_q == S_ACK); // R3
    AST_POL_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != S_ACK) |=> $stable(pol_q)); // R8

endmodule

// File: rtl/hrs_regbank.sv
module hrs_regbank
    import hrs_pkg::*;
#(
    parameter int DW    = 16,
    parameter int AW    = 9,
    parameter int IRQ_W = 8,
    parameter int N_SCR = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en_i,
    input  logic             rd_en_i,
    input  logic [AW-1:0]    addr_i,
    input  logic [DW-1:0]    wdata_i,
    input  logic [IRQ_W-1:0] evt_i,
    output logic [DW-1:0]    rdata_o,
    output pol_cfg_t         cfg_o,
    output logic             irq_n_o
);

    localparam logic [AW-1:0] A_CFG  = AW'(ADDR_CFG);
    localparam logic [AW-1:0] A_STAT = AW'(ADDR_STAT);
    localparam logic [AW-1:0] A_MASK = AW'(ADDR_MASK);

    pol_cfg_t         cfg_q;
    logic [IRQ_W-1:0] stat_q;
    logic [IRQ_W-1:0] mask_q;
    logic [IRQ_W-1:0] clr_bits;
    logic [DW-1:0]    scr_q [N_SCR];
    logic [N_SCR-1:0] scr_hit;
    logic [DW-1:0]    rd_mux;
    logic [DW-1:0]    rd_q;
    logic             irq_n_q;
    logic             wr_stat;

    assign wr_stat  = wr_en_i && (addr_i == A_STAT);
    assign clr_bits = wr_stat ? wdata_i[IRQ_W-1:0] : '0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q   <= '0;
            stat_q  <= '0;
            mask_q  <= '0;
            irq_n_q <= 1'b1;
        end else begin
            if (wr_en_i && addr_i == A_CFG)  cfg_q  <= wdata_i[CFG_W-1:0];
            if (wr_en_i && addr_i == A_MASK) mask_q <= wdata_i[IRQ_W-1:0];
            stat_q  <= (stat_q & ~clr_bits) | evt_i;
            irq_n_q <= ~|(stat_q & mask_q);
        end
    end

    for (genvar i = 0; i < N_SCR; i++) begin : g_scr
        assign scr_hit[i] = (addr_i == AW'(ADDR_SCR0 + i));
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                scr_q[i] <= '0;
            end else if (wr_en_i && scr_hit[i]) begin
                scr_q[i] <= wdata_i;
            end
        end
    end

    always_comb begin
        rd_mux = '0;
        if (addr_i == A_CFG)  rd_mux = DW'(cfg_q);
        if (addr_i == A_STAT) rd_mux = DW'(stat_q);
        if (addr_i == A_MASK) rd_mux = DW'(mask_q);
        for (int i = 0; i < N_SCR; i++) begin
            if (scr_hit[i]) rd_mux = scr_q[i];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rd_q <= '0;
        else if (rd_en_i) rd_q <= rd_mux;
    end

    assign rdata_o = rd_q;
    assign cfg_o   = cfg_q;
    assign irq_n_o = irq_n_q;

    AST_STAT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_stat |=> (stat_q & $past(stat_q)) == $past(stat_q)); // R11
    AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stat && evt_i == '0) |=> (stat_q & $past(wdata_i[IRQ_W-1:0])) == '0); // R11

endmodule

// File: rtl/host_reg_slave.sv
module host_reg_slave
    import hrs_pkg::*;
#(
    parameter int DW    = 16,
    parameter int AW    = 9,
    parameter int IRQ_W = 8,
    parameter int N_SCR = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_sel_i,
    input  logic             bus_rw_i,
    input  logic [AW-1:0]    bus_addr_i,
    inout  wire  [DW-1:0]    bus_data_io,
    output logic             bus_ack_o,
    output logic             host_irq_n_o,
    input  logic [IRQ_W-1:0] evt_i
);

    logic [1:0]    ctl_s;
    logic          wr_en;
    logic          rd_en;
    logic [AW-1:0] acc_addr;
    logic          drv_en;
    logic [DW-1:0] rdata;
    pol_cfg_t      cfg;

    hrs_sync #(.W(2), .RST_VAL(2'b11)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   ({bus_sel_i, bus_rw_i}),
        .q_o   (ctl_s)
    );

    hrs_fsm #(.AW(AW)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .sel_s_i   (ctl_s[1]),
        .rw_s_i    (ctl_s[0]),
        .sel_raw_i (bus_sel_i),
        .addr_i    (bus_addr_i),
        .cfg_i     (cfg),
        .wr_en_o   (wr_en),
        .rd_en_o   (rd_en),
        .addr_o    (acc_addr),
        .ack_o     (bus_ack_o),
        .drv_en_o  (drv_en)
    );

    hrs_regbank #(.DW(DW), .AW(AW), .IRQ_W(IRQ_W), .N_SCR(N_SCR)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en_i (wr_en),
        .rd_en_i (rd_en),
        .addr_i  (acc_addr),
        .wdata_i (bus_data_io),
        .evt_i   (evt_i),
        .rdata_o (rdata),
        .cfg_o   (cfg),
        .irq_n_o (host_irq_n_o)
    );

    assign bus_data_io = drv_en ? rdata : {DW{1'bz}};

    AST_NO_DRIVE_IN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> !drv_en); // R5

endmodule

// File: tb/host_reg_slave_tb_top.sv
module host_reg_slave_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sel = 1'b1;
    logic        rw = 1'b1;
    logic [8:0]  addr = '0;
    logic [15:0] host_d = '0;
    logic        host_oe = 1'b0;
    logic [7:0]  evt = '0;
    wire  [15:0] bus_w;
    logic        ack;
    logic        irq_n;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    // bench view of the polarity settings
    bit b_sel_hi = 1'b0;
    bit b_rw_inv = 1'b0;
    bit b_ack_hi = 1'b0;

    always #10 clk = ~clk;

    for (genvar i = 0; i < 16; i++) begin : g_pu
        pullup (bus_w[i]);
    end
    assign bus_w = host_oe ? host_d : 16'bz;

    host_reg_slave dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .bus_sel_i    (sel),
        .bus_rw_i     (rw),
        .bus_addr_i   (addr),
        .bus_data_io  (bus_w),
        .bus_ack_o    (ack),
        .host_irq_n_o (irq_n),
        .evt_i        (evt)
    );

    task automatic check(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic ack_lvl(input bit asserted);
        return asserted ? b_ack_hi : ~b_ack_hi;
    endfunction

    task automatic access(input bit is_rd, input logic [8:0] a, input logic [15:0] wd,
                          output logic [15:0] rd_v);
        bit cfg_wr;
        cfg_wr = !is_rd && (a == 9'd0);
        rd_v = '0;
        @(negedge clk);
        addr = a;
        rw   = is_rd ^ b_rw_inv;
        if (!is_rd) begin
            host_d  = wd;
            host_oe = 1'b1;
        end
        sel = b_sel_hi;
        for (int i = 1; i <= 4; i++) begin
            @(negedge clk);
            check(ack == ack_lvl(0), "R2 ack early", 16'(ack), 16'(ack_lvl(0)));
            if (is_rd && i == 4) check(bus_w == 16'hFFFF, "R5 bus before ack", bus_w, 16'hFFFF);
        end
        @(negedge clk);
        check(ack == ack_lvl(1), "R2 ack on time", 16'(ack), 16'(ack_lvl(1)));
        if (is_rd) begin
            rd_v = bus_w;
        end else begin
            host_oe = 1'b0;
            #1;
            check(bus_w == 16'hFFFF, "R5 no drive on write", bus_w, 16'hFFFF);
        end
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            check(ack == ack_lvl(1), "R3 ack held", 16'(ack), 16'(ack_lvl(1)));
        end
        sel = ~b_sel_hi;
        #1;
        check(bus_w == 16'hFFFF, "R5 release on deselect", bus_w, 16'hFFFF);
        for (int i = 0; i < 2; i++) begin
            @(negedge clk);
            check(ack == ack_lvl(1), "R3 ack through sync", 16'(ack), 16'(ack_lvl(1)));
        end
        if (cfg_wr) begin
            b_ack_hi = wd[2];
            b_rw_inv = wd[1];
            b_sel_hi = wd[0];
        end
        @(negedge clk);
        check(ack == ack_lvl(0), "R3 ack drops", 16'(ack), 16'(ack_lvl(0)));
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            check(ack == ack_lvl(0), "R9 no access before rearm", 16'(ack), 16'(ack_lvl(0)));
        end
        sel = ~b_sel_hi;
        repeat (4) @(negedge clk);
    endtask

    task automatic wr(input logic [8:0] a, input logic [15:0] d);
        logic [15:0] unused;
        access(1'b0, a, d, unused);
    endtask

    task automatic rd_chk(input logic [8:0] a, input logic [15:0] exp, input string req);
        logic [15:0] v;
        access(1'b1, a, 16'h0, v);
        check(v == exp, req, v, exp);
    endtask

    task automatic t_reset;
        @(negedge clk);
        check(ack == 1'b1, "R1 ack idle", 16'(ack), 16'h1);
        check(bus_w == 16'hFFFF, "R1 bus released", bus_w, 16'hFFFF);
        check(irq_n == 1'b1, "R1 irq idle", 16'(irq_n), 16'h1);
        rd_chk(9'd0, 16'h0000, "R1 cfg reset");
    endtask

    task automatic t_scratch;
        wr(9'd3, 16'hA55A);
        wr(9'd10, 16'h8001);
        wr(9'd6, 16'h1234);
        rd_chk(9'd3, 16'hA55A, "R4 scratch low");
        rd_chk(9'd10, 16'h8001, "R4 scratch high");
        rd_chk(9'd6, 16'h1234, "R4 scratch mid");
    endtask

    task automatic t_unmapped;
        wr(9'd11, 16'hBEEF);
        wr(9'h1FF, 16'hCAFE);
        rd_chk(9'd11, 16'h0000, "R10 unmapped 11");
        rd_chk(9'h1FF, 16'h0000, "R10 unmapped top");
        rd_chk(9'd10, 16'h8001, "R10 neighbour intact");
        rd_chk(9'd0, 16'h0000, "R10 cfg intact");
    endtask

    task automatic t_irq;
        wr(9'd2, 16'h0005);
        @(negedge clk);
        evt = 8'h01;
        @(negedge clk);
        evt = 8'h00;
        check(irq_n == 1'b1, "R12 irq not yet", 16'(irq_n), 16'h1);
        @(negedge clk);
        check(irq_n == 1'b0, "R12 irq asserted", 16'(irq_n), 16'h0);
        rd_chk(9'd1, 16'h0001, "R11 status set");
        wr(9'd1, 16'h0001);
        check(irq_n == 1'b1, "R12 irq cleared", 16'(irq_n), 16'h1);
        @(negedge clk);
        evt = 8'h02;
        @(negedge clk);
        evt = 8'h00;
        repeat (3) @(negedge clk);
        check(irq_n == 1'b1, "R12 masked bit", 16'(irq_n), 16'h1);
        wr(9'd1, 16'h0000);
        rd_chk(9'd1, 16'h0002, "R11 write zero keeps");
        wr(9'd1, 16'h0002);
        rd_chk(9'd1, 16'h0000, "R11 write one clears");
    endtask

    task automatic t_rw_pol;
        wr(9'd0, 16'h0002);
        check(b_rw_inv == 1'b1, "R7 bench state", 16'(b_rw_inv), 16'h1);
        wr(9'd4, 16'h5AA5);
        rd_chk(9'd4, 16'h5AA5, "R7 inverted rw");
        rd_chk(9'd0, 16'h0002, "R7 cfg readback");
        wr(9'd0, 16'h0000);
        rd_chk(9'd4, 16'h5AA5, "R7 restored rw");
    endtask

    task automatic t_ack_pol;
        wr(9'd0, 16'h0004);
        check(ack == 1'b0, "R8 ack idle low", 16'(ack), 16'h0);
        wr(9'd5, 16'h0F0F);
        rd_chk(9'd5, 16'h0F0F, "R8 ack high access");
        wr(9'd0, 16'h0000);
        check(ack == 1'b1, "R8 ack idle restored", 16'(ack), 16'h1);
    endtask

    task automatic t_sel_pol;
        wr(9'd0, 16'h0001);
        rd_chk(9'd0, 16'h0001, "R6 select active high");
        wr(9'd7, 16'h7E7E);
        rd_chk(9'd7, 16'h7E7E, "R6 access with high select");
        wr(9'd0, 16'h0000);
        rd_chk(9'd7, 16'h7E7E, "R6 select restored");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_scratch();
        t_unmapped();
        t_irq();
        t_rw_pol();
        t_ack_pol();
        t_sel_pol();
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_tests++;
            n_fail++;
            $display("FAIL watchdog actual=%h expected=%h", 16'h1, 16'h0);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule